// File: doc/BRIEF.md
# Instruction Tag Capture and Execution Match

This block marks instruction words for a debug breakpoint by their byte. Two active-low tag pins are sampled on each rising edge of an external bus clock. The pins are honoured only in emulation mode. The captured tag is held until the next main-processor instruction word is fetched, and then it travels with that word through a small instruction queue model. When the word leaves the queue into the execution stage, the block compares the stored tag against the bytes being executed as opcode. On a match it emits a one-cycle tag-hit pulse. The debug state sequencer uses that pulse to return to its initial state and to raise a breakpoint.

The queue is flushed on a change of flow and discards the tags held in its entries. Fetches made for the coprocessor bypass the queue and never take a tag. Every input is synchronous to the system clock `clk`. The external bus clock arrives as an ordinary level input, and the block finds its rising edges by comparing the level with the previous cycle.

Top module: `itag_capture`

## Requirements
- R1: Pins are sampled only in a cycle where `ext_clk` is 1 and was 0 in the previous cycle; holding `ext_clk` high with pins low captures nothing further. After reset the previous level counts as 1.
- R2: Tag encoding is bit 1 = high byte and bit 0 = low byte. `tag_hi_n`=0 sets bit 1 and `tag_lo_n`=0 sets bit 0, each independently of the other pin; both pins at 1 is no tag.
- R3: While `emul_mode` is 0 the pins are ignored and the pending tag is left unchanged.
- R4: A sample with either pin low replaces the pending tag completely with the new value.
- R5: A main-processor fetch (`fetch_valid`=1, `fetch_cop`=0) that is accepted stores the pending tag with the word and clears the pending tag. A sample taken in the same cycle is the one stored.
- R6: A fetch with `fetch_cop`=1 neither enters the queue nor consumes the pending tag.
- R7: A tag-hit occurs only when `q_advance` removes the oldest queued word and (stored tag AND `exec_sel`) is non-zero. `exec_sel` uses the same bit positions as R2. The result appears on the outputs in the next cycle, with `hit_hi`/`hit_lo` equal to that AND.
- R8: `q_flush` empties the queue and overrides a fetch or an advance in the same cycle. The pending tag is kept.
- R9: `tag_hit` is a registered one-cycle pulse per matching advance. An advance on an empty queue, or one without a match, gives all outputs 0.
- R10: Synchronous reset clears the pending tag, empties the queue and drives all outputs to 0.
- R11: A fetch into a full queue is dropped unless an advance frees a slot in the same cycle. A dropped fetch leaves the pending tag in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External bus clock level, synchronous to clk |
| tag_hi_n | input | 1 | Active-low tag request for the high byte |
| tag_lo_n | input | 1 | Active-low tag request for the low byte |
| emul_mode | input | 1 | Emulation mode; enables tag capture |
| fetch_valid | input | 1 | An instruction word is fetched this cycle |
| fetch_cop | input | 1 | The fetch belongs to the coprocessor |
| q_advance | input | 1 | Oldest queued word moves into execution |
| q_flush | input | 1 | Discard all queued words |
| exec_sel | input | 2 | Bytes of the executing word that are opcode (bit 1 high, bit 0 low) |
| tag_hit | output | 1 | One-cycle tag-hit pulse to the state sequencer |
| hit_hi | output | 1 | Tag-hit involved the high byte |
| hit_lo | output | 1 | Tag-hit involved the low byte |

## Verification
A corrupted pending tag, queue pointer or entry has no visible effect at the moment it goes wrong. It only shows up when the affected word reaches execution, one cycle after the advance that removes it. At that point it appears as a missing, extra or wrongly-bytewise pulse. For this reason the stimulus always follows captures and flushes with enough fetches and advances to drain the queue. It also varies the queue depth at which a tagged word sits, so a fault in the entries is exposed within the few cycles needed to drain.

// File: rtl/itag_pkg.sv
package itag_pkg;
  typedef logic [1:0] tag_t;
  localparam tag_t TAG_NONE = 2'b00;
  localparam int   HI_BIT   = 1;
  localparam int   LO_BIT   = 0;

  function automatic tag_t pins_to_tag(input logic hi_n, input logic lo_n);
    tag_t t;
    t         = TAG_NONE;
    t[HI_BIT] = ~hi_n;
    t[LO_BIT] = ~lo_n;
    return t;
  endfunction
endpackage

// File: rtl/itag_sampler.sv
module itag_sampler
  import itag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  input  logic tag_hi_n,
  input  logic tag_lo_n,
  input  logic emul_mode,
  input  logic take,
  output tag_t cur_tag
);
  logic ext_q;
  logic ext_rise;
  logic sample_vld;
  tag_t pin_tag;
  tag_t pending;

  assign ext_rise   = ext_clk & ~ext_q;
  assign pin_tag    = pins_to_tag(tag_hi_n, tag_lo_n);
  assign sample_vld = ext_rise & emul_mode & (pin_tag != TAG_NONE);
  assign cur_tag    = sample_vld ? pin_tag : pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q   <= 1'b1;
      pending <= TAG_NONE;
    end else begin
      ext_q <= ext_clk;
      if (take) pending <= TAG_NONE;
      else if (sample_vld) pending <= pin_tag;
    end
  end

  p_no_capture_outside_emul_r3: assert property (@(posedge clk) disable iff (rst)
    (!emul_mode && !take) |=> $stable(pending));

  p_level_not_edge_r1: assert property (@(posedge clk) disable iff (rst)
    (!(ext_clk && !ext_q) && !take) |=> $stable(pending));

  p_both_pins_r2: assert property (@(posedge clk) disable iff (rst)
    (ext_rise && emul_mode && !take && !tag_hi_n && !tag_lo_n) |=> (pending == 2'b11));
endmodule

// File: rtl/itag_queue.sv
module itag_queue
  import itag_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  tag_t push_tag,
  input  logic pop,
  input  logic flush,
  output tag_t head_tag,
  output logic pop_ok,
  output logic push_ok
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  tag_t          mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic          empty;
  logic          full;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign pop_ok   = pop & ~empty & ~flush;
  assign push_ok  = push & ~flush & (~full | pop_ok);
  assign head_tag = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
endmodule

// File: rtl/itag_hit.sv
module itag_hit
  import itag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pop_ok,
  input  tag_t head_tag,
  input  tag_t exec_sel,
  output logic tag_hit,
  output logic hit_hi,
  output logic hit_lo
);
  tag_t match;

  assign match = pop_ok ? (head_tag & exec_sel) : TAG_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_hit <= 1'b0;
      hit_hi  <= 1'b0;
      hit_lo  <= 1'b0;
    end else begin
      tag_hit <= |match;
      hit_hi  <= match[HI_BIT];
      hit_lo  <= match[LO_BIT];
    end
  end
endmodule

// File: rtl/itag_capture.sv
module itag_capture
  import itag_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_clk,
  input  logic       tag_hi_n,
  input  logic       tag_lo_n,
  input  logic       emul_mode,
  input  logic       fetch_valid,
  input  logic       fetch_cop,
  input  logic       q_advance,
  input  logic       q_flush,
  input  logic [1:0] exec_sel,
  output logic       tag_hit,
  output logic       hit_hi,
  output logic       hit_lo
);
  tag_t cur_tag;
  tag_t head_tag;
  logic cpu_fetch;
  logic push_ok;
  logic pop_ok;

  assign cpu_fetch = fetch_valid & ~fetch_cop;

  itag_sampler u_sampler (
    .clk      (clk),
    .rst      (rst),
    .ext_clk  (ext_clk),
    .tag_hi_n (tag_hi_n),
    .tag_lo_n (tag_lo_n),
    .emul_mode(emul_mode),
    .take     (push_ok),
    .cur_tag  (cur_tag)
  );

  itag_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .push    (cpu_fetch),
    .push_tag(cur_tag),
    .pop     (q_advance),
    .flush   (q_flush),
    .head_tag(head_tag),
    .pop_ok  (pop_ok),
    .push_ok (push_ok)
  );

  itag_hit u_hit (
    .clk     (clk),
    .rst     (rst),
    .pop_ok  (pop_ok),
    .head_tag(head_tag),
    .exec_sel(exec_sel),
    .tag_hit (tag_hit),
    .hit_hi  (hit_hi),
    .hit_lo  (hit_lo)
  );

  p_hit_needs_advance_r7: assert property (@(posedge clk) disable iff (rst)
    tag_hit |-> $past(q_advance && !q_flush));

  p_hit_has_byte_r9: assert property (@(posedge clk) disable iff (rst)
    tag_hit |-> (hit_hi || hit_lo));

  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!tag_hit && !hit_hi && !hit_lo));
endmodule

// File: tb/tb_itag_capture.sv
module tb_itag_capture;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_clk = 1'b0, tag_hi_n = 1'b1, tag_lo_n = 1'b1, emul_mode = 1'b1;
  logic fetch_valid = 1'b0, fetch_cop = 1'b0, q_advance = 1'b0, q_flush = 1'b0;
  logic [1:0] exec_sel = 2'b00;
  logic tag_hit, hit_hi, hit_lo;

  always #10 clk = ~clk;

  itag_capture #(.QDEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .tag_hi_n(tag_hi_n), .tag_lo_n(tag_lo_n),
    .emul_mode(emul_mode), .fetch_valid(fetch_valid), .fetch_cop(fetch_cop),
    .q_advance(q_advance), .q_flush(q_flush), .exec_sel(exec_sel),
    .tag_hit(tag_hit), .hit_hi(hit_hi), .hit_lo(hit_lo)
  );

  typedef struct {
    logic  hit;
    logic  hi;
    logic  lo;
    string req;
  } exp_t;

  exp_t       sbq[$];
  int         total = 0;
  int         bad = 0;
  bit         done = 0;
  logic       m_ext_prev = 1'b1;
  logic [1:0] m_pend = 2'b00;
  logic [1:0] m_q[$];

  task automatic report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic cyc(input bit ext, input bit hin, input bit lon, input bit em,
                     input bit fv, input bit cop, input bit adv, input logic [1:0] sel,
                     input bit fl, input string req);
    logic [1:0] samp, cur, h;
    bit popped;
    exp_t e;
    @(negedge clk);
    ext_clk = ext; tag_hi_n = hin; tag_lo_n = lon; emul_mode = em;
    fetch_valid = fv; fetch_cop = cop; q_advance = adv; exec_sel = sel; q_flush = fl;
    samp = (ext && !m_ext_prev && em && (!hin || !lon)) ? {~hin, ~lon} : 2'b00;
    m_ext_prev = ext;
    cur = (samp != 2'b00) ? samp : m_pend;
    h = 2'b00;
    popped = 0;
    if (fl) begin
      m_q.delete();
      m_pend = cur;
    end else begin
      if (adv && m_q.size() > 0) begin
        h = m_q.pop_front() & sel;
        popped = 1;
      end
      if (fv && !cop && (m_q.size() < DEPTH || popped)) begin
        m_q.push_back(cur);
        m_pend = 2'b00;
      end else begin
        m_pend = cur;
      end
    end
    e.hit = (h != 2'b00); e.hi = h[1]; e.lo = h[0]; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic idle(input string req);
    cyc(0, 1, 1, 1, 0, 0, 0, 2'b00, 0, req);
  endtask
  task automatic tag_edge(input bit hin, input bit lon, input bit em, input string req);
    cyc(0, 1, 1, em, 0, 0, 0, 2'b00, 0, req);
    cyc(1, hin, lon, em, 0, 0, 0, 2'b00, 0, req);
  endtask
  task automatic fetch(input string req);
    cyc(0, 1, 1, 1, 1, 0, 0, 2'b00, 0, req);
  endtask
  task automatic adv(input logic [1:0] sel, input string req);
    cyc(0, 1, 1, 1, 0, 0, 1, sel, 0, req);
  endtask
  task automatic drain(input string req);
    for (int i = 0; i < DEPTH + 1; i++) adv(2'b11, req);
  endtask

  // scoreboard monitor: one expected item per clock edge after it was pushed
  initial forever begin
    @(posedge clk);
    #5;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      total++;
      if (tag_hit !== e.hit || hit_hi !== e.hi || hit_lo !== e.lo) begin
        bad++;
        $display("FAIL %s: got hit=%b hi=%b lo=%b exp hit=%b hi=%b lo=%b",
                 e.req, tag_hit, hit_hi, hit_lo, e.hit, e.hi, e.lo);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout exp finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    total++;
    if (tag_hit !== 1'b0 || hit_hi !== 1'b0 || hit_lo !== 1'b0) begin
      bad++;
      $display("FAIL R10: got %b%b%b exp 000", tag_hit, hit_hi, hit_lo);
    end
    idle("R10");
    fetch("R10"); adv(2'b11, "R10");

    // R2: every pin combination, independent decode
    for (int k = 0; k < 4; k++) begin
      tag_edge(k[1], k[0], 1, "R2");
      fetch("R2");
      adv(2'b11, "R2");
      idle("R2");
    end

    // R1: level held high is not a new edge
    tag_edge(1, 1, 1, "R1");
    cyc(1, 0, 0, 1, 0, 0, 0, 2'b00, 0, "R1");
    cyc(1, 0, 1, 1, 0, 0, 0, 2'b00, 0, "R1");
    fetch("R1"); adv(2'b11, "R1"); idle("R1");

    // R3: emulation off ignores pins, pending untouched
    tag_edge(1, 0, 1, "R3");
    tag_edge(0, 0, 0, "R3");
    fetch("R3"); adv(2'b11, "R3"); idle("R3");

    // R4: newer sample replaces older one
    tag_edge(1, 0, 1, "R4");
    tag_edge(0, 1, 1, "R4");
    fetch("R4"); adv(2'b11, "R4");
    fetch("R4"); adv(2'b11, "R4"); idle("R4");

    // R5: same-cycle sample and fetch, pending cleared afterwards
    cyc(0, 1, 1, 1, 0, 0, 0, 2'b00, 0, "R5");
    cyc(1, 0, 1, 1, 1, 0, 0, 2'b00, 0, "R5");
    fetch("R5"); adv(2'b11, "R5"); adv(2'b11, "R5"); idle("R5");

    // R6: coprocessor fetch does not consume tag
    tag_edge(1, 0, 1, "R6");
    cyc(0, 1, 1, 1, 1, 1, 0, 2'b00, 0, "R6");
    adv(2'b11, "R6");
    fetch("R6"); adv(2'b11, "R6"); adv(2'b11, "R6"); idle("R6");

    // R7: tag on third queued word, byte select masks
    fetch("R7"); fetch("R7");
    tag_edge(0, 1, 1, "R7");
    fetch("R7");
    tag_edge(1, 0, 1, "R7");
    fetch("R7");
    adv(2'b11, "R7"); adv(2'b11, "R7"); adv(2'b01, "R7"); adv(2'b10, "R7");
    tag_edge(0, 0, 1, "R7");
    fetch("R7"); adv(2'b01, "R7"); idle("R7");

    // R9: back-to-back matching advances and advance on empty
    tag_edge(0, 0, 1, "R9"); fetch("R9");
    tag_edge(1, 0, 1, "R9"); fetch("R9");
    adv(2'b11, "R9"); adv(2'b11, "R9"); adv(2'b11, "R9"); idle("R9");

    // R8: flush discards entries and beats same-cycle fetch/advance
    tag_edge(0, 0, 1, "R8"); fetch("R8");
    tag_edge(0, 1, 1, "R8"); fetch("R8");
    cyc(0, 1, 1, 1, 0, 0, 1, 2'b11, 1, "R8");
    adv(2'b11, "R8");
    tag_edge(1, 0, 1, "R8");
    cyc(0, 1, 1, 1, 1, 0, 0, 2'b00, 1, "R8");
    adv(2'b11, "R8");
    fetch("R8"); adv(2'b11, "R8"); idle("R8");

    // R11: full queue drops fetch and keeps tag pending
    for (int i = 0; i < DEPTH; i++) fetch("R11");
    tag_edge(0, 1, 1, "R11");
    fetch("R11");
    for (int i = 0; i < DEPTH; i++) adv(2'b11, "R11");
    fetch("R11"); adv(2'b11, "R11"); idle("R11");
    for (int i = 0; i < DEPTH; i++) fetch("R11");
    tag_edge(1, 0, 1, "R11");
    cyc(0, 1, 1, 1, 1, 0, 1, 2'b11, 0, "R11");
    drain("R11"); idle("R11");

    repeat (3) @(negedge clk);
    report();
  end
endmodule